// File: doc/BRIEF.md
# Weighted Bus Arbiter with CPU Default Grant

This block decides which master owns a shared 32-bit internal bus. Every master has its own request line. The arbiter hands the bus to one master at a time for a whole block transfer, and it takes the bus back only when the current owner signals that its block is finished. Master 0 is the processor. The other masters are peripherals.

A peripheral that requests always wins over the processor. The processor gets the bus whenever no peripheral wants it. When nothing is requested at all, the grant stays parked on the processor.

A configuration input selects one of two policies for sharing the bus among peripherals:
- **Plain rotation:** each peripheral gets one block per turn.
- **Weighted rotation:** each peripheral may keep the bus for several consecutive blocks before the turn moves on. The number of blocks is set by a small programmable weight per peripheral.

In both policies, every requesting peripheral gets a guaranteed share of the bus and a bounded wait. Moving data and decoding slaves are handled elsewhere.

Top module: `shared_bus_arbiter`

## Requirements
- R1: Exactly one bit of `grant` is high at all times. After reset, `grant` selects master 0 and `blk_active` is low.
- R2: An arbitration point is any cycle with no block active, or a cycle in which `xfer_done` is high. If any peripheral requests at an arbitration point, a peripheral is granted, and `blk_active` is high from the next cycle on.
- R3: If no peripheral requests at an arbitration point, `grant` selects master 0 in the next cycle, whether or not master 0 requests. `blk_active` is then high only if `req[0]` was high.
- R4: While a block is active and `xfer_done` is low, `grant` does not change. Raising `xfer_done` makes that cycle an arbitration point, so the next owner appears in the following cycle with no idle cycle in between.
- R5: When `cfg_mode` is 0 (plain rotation), each decision picks the first requesting peripheral after the last one granted, in ascending index order with wraparound. Peripheral 5 is followed by peripheral 1. After reset, the search starts at peripheral 1.
- R6: When `cfg_mode` is 1 (weighted rotation), the last granted peripheral keeps winning at later arbitration points while it still requests and has received fewer than its weight in consecutive grants. After that, the turn moves on as in R5. The weight of master i occupies `cfg_weight[4(i-1)+3 : 4(i-1)]`.
- R7: A weight of 0 behaves as a weight of 1.
- R8: `cfg_mode` and `cfg_weight` are sampled only at arbitration points. Changing them while a block is active leaves the current grant unchanged, and the new setting governs the next decision.
- R9: A requesting peripheral that holds its request is granted after no more grants to other peripherals than the sum of the other peripherals' effective weights.
- R10: A grant to master 0 ends the current peripheral's run. At the next decision, the turn moves past the last granted peripheral even if that peripheral has weight left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | N_MST | Request line per master; bit 0 is the processor |
| xfer_done | input | 1 | Current owner finishes its block in this cycle |
| cfg_mode | input | 1 | Policy: 0 plain rotation, 1 weighted rotation |
| cfg_weight | input | (N_MST-1)*WEIGHT_W | Packed weights of the peripherals, master 1 in the low bits |
| grant | output | N_MST | One-hot grant to the bus owner |
| blk_active | output | 1 | A block transfer is in progress |

## Verification
The bench uses the default build: six masters (the processor and five peripherals) and 4-bit weights. The weights are programmed to small values (2, 0, 3, 1, 1), so that a weighted run, the zero-as-one rule and a complete rotation each finish within a few blocks. With five peripherals, a plain rotation returns to its starting point after five grants. That keeps the wraparound and the run cut short by a processor block within reach. The worst-case wait for the last peripheral, seven blocks, can then be measured directly.

// File: rtl/arb_pkg.sv
// Package shared by the bus arbiter modules.
// Assumes: index 0 of the request vector belongs to the processor.
package arb_pkg;

    // Allocation policy, selected by the 1-bit configuration input.
    typedef enum logic {
        ARB_MODE_RR  = 1'b0,
        ARB_MODE_WRR = 1'b1
    } arb_mode_e;

    // Master index of the processor, which takes all leftover slots.
    localparam int unsigned ARB_CPU_ID = 0;

endpackage

// File: rtl/arb_rr_pick.sv
// Rotating priority search over the peripheral requests.
// Returns the first requester after position 'last', wrapping around, so the
// last winner itself has the lowest priority.
// Assumes: last < NP.
module arb_rr_pick #(
    parameter int unsigned NP = 5,
    parameter int unsigned PW = 3
) (
    input  logic [NP-1:0] req_p,
    input  logic [PW-1:0] last,
    output logic          found,
    output logic [PW-1:0] pick
);

    // Scan the distances from the farthest down to the nearest; the nearest requester wins.
    always_comb begin
        int idx;
        found = 1'b0;
        pick  = '0;
        idx   = 0;
        for (int k = NP; k >= 1; k--) begin
            idx = (int'(last) + k) % NP;
            if (req_p[idx]) begin
                found = 1'b1;
                pick  = PW'(idx);
            end
        end
    end

endmodule

// File: rtl/arb_credit_ctl.sv
// Turn pointer and run counter for the peripherals.
// Decides whether the last winner keeps the bus (weighted mode, weight left)
// or whether the rotating search result takes over. State moves only on
// arbitration points (dec_en).
// Assumes: weights are stable while a run is counted.
module arb_credit_ctl
    import arb_pkg::*;
#(
    parameter int unsigned NP = 5,
    parameter int unsigned WW = 4,
    parameter int unsigned PW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_en,
    input  arb_mode_e        mode,
    input  logic [NP*WW-1:0] cfg_weight,
    input  logic [NP-1:0]    req_p,
    input  logic             rr_found,
    input  logic [PW-1:0]    rr_pick,
    output logic [PW-1:0]    last_q,
    output logic [PW-1:0]    sel,
    output logic             sel_valid
);

    logic [WW-1:0] eff_w [NP];
    logic [WW-1:0] cnt_q;
    logic          stay;

    // Effective weight per peripheral; zero is promoted to one.
    for (genvar i = 0; i < NP; i++) begin : g_eff
        assign eff_w[i] = (cfg_weight[i*WW +: WW] == '0) ? WW'(1) : cfg_weight[i*WW +: WW];
    end

    // Keep the current winner while it requests and has weight left.
    always_comb begin
        stay      = (mode == ARB_MODE_WRR) && req_p[last_q] && (cnt_q < eff_w[last_q]);
        sel       = stay ? last_q : rr_pick;
        sel_valid = rr_found;
    end

    // Advance the turn pointer and the run counter at each decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= PW'(NP - 1);
            cnt_q  <= '1;
        end else if (dec_en) begin
            if (!rr_found) begin
                cnt_q <= '1;
            end else if (stay) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                last_q <= rr_pick;
                cnt_q  <= WW'(1);
            end
        end
    end

    // R6
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && rr_found) |=> ((cnt_q != '0) && (cnt_q <= eff_w[last_q])));

endmodule

// File: rtl/shared_bus_arbiter.sv
// Central arbiter for a shared internal bus.
// Grants one master per block transfer and holds the grant until xfer_done.
// Peripherals (masters 1..N_MST-1) share the bus by plain or weighted
// rotation; the processor (master 0) receives every slot no peripheral wants
// and is the parked owner when the bus is idle.
// Assumes: a peripheral keeps its request high until it is granted.
module shared_bus_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned N_MST    = 6,
    parameter int unsigned WEIGHT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_MST-1:0]             req,
    input  logic                         xfer_done,
    input  logic                         cfg_mode,
    input  logic [(N_MST-1)*WEIGHT_W-1:0] cfg_weight,
    output logic [N_MST-1:0]             grant,
    output logic                         blk_active
);

    localparam int unsigned NP  = N_MST - 1;
    localparam int unsigned PW  = (NP > 1) ? $clog2(NP) : 1;
    localparam int unsigned IDW = $clog2(N_MST);

    logic [NP-1:0]  req_p;
    logic           dec_en;
    logic           rr_found;
    logic [PW-1:0]  rr_pick;
    logic [PW-1:0]  last_q;
    logic [PW-1:0]  sel;
    logic           sel_valid;
    logic [IDW-1:0] owner_q;
    logic           active_q;

    // Peripheral requests and the arbitration-point strobe.
    always_comb begin
        req_p  = req[N_MST-1:1];
        dec_en = !active_q || xfer_done;
    end

    arb_rr_pick #(
        .NP (NP),
        .PW (PW)
    ) u_pick (
        .req_p (req_p),
        .last  (last_q),
        .found (rr_found),
        .pick  (rr_pick)
    );

    arb_credit_ctl #(
        .NP (NP),
        .WW (WEIGHT_W),
        .PW (PW)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_en     (dec_en),
        .mode       (arb_mode_e'(cfg_mode)),
        .cfg_weight (cfg_weight),
        .req_p      (req_p),
        .rr_found   (rr_found),
        .rr_pick    (rr_pick),
        .last_q     (last_q),
        .sel        (sel),
        .sel_valid  (sel_valid)
    );

    // Register the owner at each arbitration point; leftover slots go to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q  <= IDW'(ARB_CPU_ID);
            active_q <= 1'b0;
        end else if (dec_en) begin
            if (sel_valid) begin
                owner_q  <= IDW'(sel) + IDW'(1);
                active_q <= 1'b1;
            end else begin
                owner_q  <= IDW'(ARB_CPU_ID);
                active_q <= req[ARB_CPU_ID];
            end
        end
    end

    // Decode the owner into the one-hot grant.
    always_comb begin
        grant          = '0;
        grant[owner_q] = 1'b1;
        blk_active     = active_q;
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) == 1);

    // R2
    periph_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && (|req_p)) |=> (!grant[0] && blk_active));

    // R3
    cpu_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !(|req_p)) |=> grant[0]);

    // R3
    cpu_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !(|req_p) && !req[0]) |=> !blk_active);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_active && !xfer_done) |=> ($stable(grant) && blk_active));

    // Effective weight of peripheral j, used for the wait bound.
    function automatic logic [7:0] eff_of(input int j);
        logic [WEIGHT_W-1:0] w;
        w = cfg_weight[j*WEIGHT_W +: WEIGHT_W];
        return (w == '0) ? 8'd1 : 8'(w);
    endfunction

    // R9 wait counter per peripheral: grants to others while it waits.
    for (genvar i = 0; i < NP; i++) begin : g_wait
        logic [7:0] wait_q;
        logic [7:0] bound;

        // Sum of the other peripherals' effective weights.
        always_comb begin
            bound = '0;
            for (int j = 0; j < NP; j++) begin
                if (j != i) bound = bound + eff_of(j);
            end
        end

        // Count decisions lost while requesting; clear when served or idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wait_q <= '0;
            end else if (dec_en) begin
                if (req_p[i] && sel_valid && (sel != PW'(i))) wait_q <= wait_q + 8'd1;
                else                                         wait_q <= '0;
            end
        end

        // R9
        wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q <= bound);
    end

endmodule

// File: tb/shared_bus_arbiter_test.sv
module shared_bus_arbiter_test;

    localparam int N  = 6;
    localparam int WW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      req = '0;
    logic              xfer_done = 1'b0;
    logic              cfg_mode = 1'b0;
    logic [(N-1)*WW-1:0] cfg_weight = 20'h11302; // p1=2 p2=0 p3=3 p4=1 p5=1
    logic [N-1:0]      grant;
    logic              blk_active;

    int n_vec = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    typedef struct {
        int    id;
        bit    act;
        string tag;
    } exp_t;

    exp_t sbq[$];

    always #5 clk = ~clk;

    shared_bus_arbiter #(.N_MST(N), .WEIGHT_W(WW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .xfer_done  (xfer_done),
        .cfg_mode   (cfg_mode),
        .cfg_weight (cfg_weight),
        .grant      (grant),
        .blk_active (blk_active)
    );

    function automatic void check(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endfunction

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Driver: one cycle of stimulus, expected owner queued for the monitor.
    task automatic step(input logic [N-1:0] r, input bit d, input int id, input bit act,
                        input string tag);
        @(negedge clk);
        req       = r;
        xfer_done = d;
        @(posedge clk);
        #1;
        sbq.push_back('{id, act, tag});
    endtask

    // Monitor: compare grant and activity against the queued expectation.
    always @(negedge clk) begin
        exp_t e;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            check((grant == N'(1 << e.id)) && (blk_active == e.act), e.tag,
                  {grant, 3'b0, blk_active}, {N'(1 << e.id), 3'b0, e.act});
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int waits;
        bit seen5;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check((grant == 6'b000001) && !blk_active, "R1 reset", {grant, blk_active}, {6'b000001, 1'b0});
        @(negedge clk);
        rst_n = 1'b1;

        // R3 parked and CPU block
        step(6'b000000, 0, 0, 0, "R3 parked no request");
        step(6'b000001, 0, 0, 1, "R3 cpu block");
        step(6'b000101, 0, 0, 1, "R4 hold cpu block");
        step(6'b000100, 1, 2, 1, "R2 peripheral wins");

        // R5 plain rotation, all peripherals
        step(6'b111110, 1, 3, 1, "R5 rr p3");
        step(6'b111110, 1, 4, 1, "R5 rr p4");
        step(6'b111110, 1, 5, 1, "R5 rr p5");
        step(6'b111110, 1, 1, 1, "R5 rr wrap p1");
        step(6'b111110, 1, 2, 1, "R5 rr p2");
        step(6'b111110, 0, 2, 1, "R4 hold");
        step(6'b010010, 1, 4, 1, "R5 sparse p4");
        step(6'b010010, 1, 1, 1, "R5 sparse p1");
        step(6'b010010, 1, 4, 1, "R5 sparse p4 again");

        // R8 mode change mid-block
        cfg_mode = 1'b1;
        step(6'b011010, 0, 4, 1, "R8 mode change holds");

        // R6 weighted rotation
        step(6'b011010, 1, 1, 1, "R6 w p1 first");
        step(6'b011010, 1, 1, 1, "R6 w p1 second");
        step(6'b011010, 1, 3, 1, "R6 w p3 1");
        step(6'b011010, 1, 3, 1, "R6 w p3 2");
        step(6'b011010, 1, 3, 1, "R6 w p3 3");
        step(6'b011010, 1, 4, 1, "R6 w p4");
        step(6'b011010, 1, 1, 1, "R6 w back p1");

        // R7 zero weight acts as one
        step(6'b001100, 1, 2, 1, "R7 p2 once");
        step(6'b001100, 1, 3, 1, "R7 p3 1");
        step(6'b001100, 1, 3, 1, "R7 p3 2");
        step(6'b001100, 1, 3, 1, "R7 p3 3");
        step(6'b001100, 1, 2, 1, "R7 p2 again");
        step(6'b001100, 1, 3, 1, "R7 p3 run start");

        // R10 cpu block ends the peripheral run
        step(6'b000001, 1, 0, 1, "R10 cpu block");
        step(6'b000001, 0, 0, 1, "R10 cpu hold");
        step(6'b011000, 1, 4, 1, "R10 run ended");

        // R9 worst wait for p5 with everyone requesting
        step(6'b111110, 1, 5, 1, "R9 p5 served");
        @(negedge clk);
        waits = 0;
        seen5 = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (!seen5) begin
                req       = 6'b111110;
                xfer_done = 1'b1;
                @(posedge clk);
                #1;
                if (grant[5]) seen5 = 1'b1;
                else          waits++;
                @(negedge clk);
            end
        end
        check(seen5 && (waits <= 7), "R9 wait bound", waits, 7);

        // R3 idle again
        step(6'b000000, 1, 0, 0, "R3 back to parked");
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end

endmodule